// File: doc/BRIEF.md
# Interrupt Acknowledge Hold Unit

This block decides, at each instruction boundary, whether an interrupt request that the priority resolver reports as pending may be taken by the CPU. It sits between the priority logic and the CPU sequencer. The sequencer gives it an instruction-end strobe and a 3-bit class code for the instruction that is finishing. The priority logic gives it a pending flag. The status word gives it the global interrupt-enable bit.

Some instructions must never be followed at once by interrupt entry. These are writes to the status word, the two return instructions, interrupt enable and disable, the conditional skips, and writes to the interrupt flag, mask or priority registers. When one of them ends, the unit sets a one-bit hold flag. The flag blocks acknowledgment at the end of the next instruction as well. The next boundary that ends a non-hold instruction with the flag clear may acknowledge. At that boundary the unit raises, for one cycle, an acknowledge pulse together with a request to save the status word and the program counter.

The acknowledge is combinational on the strobe cycle, so the sequencer sees it in the same clock as its own boundary. Only the hold flag is registered.

Top module: `iah_unit`

## Requirements
- R1: While the synchronous reset `rst` is high, `irq_ack_o` and `ctx_save_o` stay low. On release the hold flag is clear, so the first qualifying boundary acknowledges.
- R2: When `instr_end` is high, the class is ordinary, the hold flag is clear, `irq_enable` is high and `irq_pending` is high, `irq_ack_o` is high in that same cycle.
- R3: `irq_ack_o` is never high in a cycle where `instr_end` is low.
- R4: `irq_ack_o` stays low at any boundary where `irq_enable` or `irq_pending` is low.
- R5: Class codes 1 (status-word write), 2 (return), 3 (enable/disable), 4 (conditional skip) and 5 (interrupt flag/mask/priority register write) are hold-class. No acknowledge occurs at the boundary that ends one of them.
- R6: At the boundary that follows a hold-class boundary, no acknowledge occurs, whatever the class of the finishing instruction.
- R7: A run of consecutive hold-class boundaries keeps deferring acknowledgment. The first ordinary boundary after the run is also blocked, and the boundary after that may acknowledge.
- R8: `ctx_save_o` equals `irq_ack_o` in every cycle.
- R9: Class codes 0, 6 and 7 are ordinary. They clear the hold flag at their boundary and may themselves be acknowledged.
- R10: The hold flag changes only in cycles where `instr_end` is high. The class code, pending flag and enable bit are ignored between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_end | input | 1 | High for one cycle per finishing instruction |
| instr_class | input | 3 | Class code of the finishing instruction (0 = ordinary) |
| irq_pending | input | 1 | A resolved interrupt request is waiting |
| irq_enable | input | 1 | Global interrupt-enable bit |
| irq_ack_o | output | 1 | One-cycle acknowledge, on the strobe cycle |
| ctx_save_o | output | 1 | Request to save status word and program counter |

## Verification
Two things can fall in the same cycle: a boundary that ends a hold-class instruction, and a boundary that would otherwise acknowledge a pending request. Which one wins depends on the hold flag left by the previous boundary. The bench provokes the clash by sweeping every pair of consecutive class codes, against every combination of pending and enable. It runs the sweep with and without an idle cycle between the two strobes. The idle cycle carries a hold-class code to tempt a stray flag update. A bench model of the hold flag, built from the class list in the requirements, decides each cycle whether the acknowledge must be high. Each cycle is judged at the ports, against `irq_ack_o` and `ctx_save_o`.

// File: rtl/iah_pkg.sv
package iah_pkg;

    localparam int CLASS_W = 3;
    localparam int NUM_CLASSES = 1 << CLASS_W;

    typedef enum logic [CLASS_W-1:0] {
        CLS_PLAIN     = 3'd0,
        CLS_STATUS_WR = 3'd1,
        CLS_RETURN    = 3'd2,
        CLS_IEN_CTRL  = 3'd3,
        CLS_COND_SKIP = 3'd4,
        CLS_INTC_WR   = 3'd5,
        CLS_SPARE_6   = 3'd6,
        CLS_SPARE_7   = 3'd7
    } instr_class_e;

    // One bit per class code: set means the class defers acknowledgment.
    localparam logic [NUM_CLASSES-1:0] HOLD_MASK_DEF = 8'b0011_1110;

    typedef struct packed {
        logic hold;
    } iah_state_t;

endpackage

// File: rtl/iah_class_decode.sv
module iah_class_decode #(
    parameter int CLASS_W = iah_pkg::CLASS_W,
    parameter logic [(1<<CLASS_W)-1:0] HOLD_MASK = iah_pkg::HOLD_MASK_DEF
) (
    input  logic [CLASS_W-1:0] cls,
    output logic               is_hold
);
    localparam int NCODES = 1 << CLASS_W;

    logic [NCODES-1:0] hit;

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        if (HOLD_MASK[g]) begin : g_hold
            assign hit[g] = (cls == CLASS_W'(g));
        end else begin : g_plain
            assign hit[g] = 1'b0;
        end
    end

    assign is_hold = |hit;
endmodule

// File: rtl/iah_ack_gate.sv
module iah_ack_gate (
    input  logic rst,
    input  logic boundary,
    input  logic cls_hold,
    input  logic hold_q,
    input  logic ien,
    input  logic pend,
    output logic ack
);
    logic deferred;
    logic allowed;

    always_comb begin
        deferred = hold_q | cls_hold;
        allowed  = ien & pend;
        ack      = ~rst & boundary & ~deferred & allowed;
    end
endmodule

// File: rtl/iah_unit.sv
module iah_unit #(
    parameter int CLASS_W = iah_pkg::CLASS_W,
    parameter logic [(1<<CLASS_W)-1:0] HOLD_MASK = iah_pkg::HOLD_MASK_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_end,
    input  logic [CLASS_W-1:0] instr_class,
    input  logic               irq_pending,
    input  logic               irq_enable,
    output logic               irq_ack_o,
    output logic               ctx_save_o
);
    import iah_pkg::*;

    iah_state_t st_d, st_q;
    logic       cls_hold;
    logic       ack;

    iah_class_decode #(
        .CLASS_W   (CLASS_W),
        .HOLD_MASK (HOLD_MASK)
    ) u_decode (
        .cls     (instr_class),
        .is_hold (cls_hold)
    );

    iah_ack_gate u_gate (
        .rst      (rst),
        .boundary (instr_end),
        .cls_hold (cls_hold),
        .hold_q   (st_q.hold),
        .ien      (irq_enable),
        .pend     (irq_pending),
        .ack      (ack)
    );

    // Next-state: the hold flag follows the class of each finishing instruction.
    always_comb begin
        st_d = st_q;
        if (instr_end) begin
            st_d.hold = cls_hold;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign irq_ack_o  = ack;
    assign ctx_save_o = ack;
endmodule

// File: rtl/iah_unit_checker.sv
module iah_unit_checker #(
    parameter int CLASS_W = iah_pkg::CLASS_W
) (
    input logic               clk,
    input logic               rst,
    input logic               instr_end,
    input logic [CLASS_W-1:0] instr_class,
    input logic               irq_pending,
    input logic               irq_enable,
    input logic               irq_ack_o,
    input logic               ctx_save_o
);
    logic chk_cls_hold;
    logic chk_prev_hold;

    assign chk_cls_hold = (instr_class >= CLASS_W'(1)) && (instr_class <= CLASS_W'(5));

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_prev_hold <= 1'b0;
        end else if (instr_end) begin
            chk_prev_hold <= chk_cls_hold;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R1: assert (!irq_ack_o && !ctx_save_o);
        end
    end

    assert_take_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_end && !chk_cls_hold && !chk_prev_hold && irq_enable && irq_pending) |-> irq_ack_o);

    assert_ack_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        irq_ack_o |-> instr_end);

    assert_ack_needs_request_R4: assert property (@(posedge clk) disable iff (rst)
        (!irq_enable || !irq_pending) |-> !irq_ack_o);

    assert_hold_class_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_end && chk_cls_hold) |-> !irq_ack_o);

    assert_deferred_next_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_end && chk_prev_hold) |-> !irq_ack_o);

    assert_ctx_matches_R8: assert property (@(posedge clk) disable iff (rst)
        ctx_save_o == irq_ack_o);
endmodule

bind iah_unit iah_unit_checker #(.CLASS_W(CLASS_W)) u_iah_unit_checker (
    .clk         (clk),
    .rst         (rst),
    .instr_end   (instr_end),
    .instr_class (instr_class),
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_ack_o   (irq_ack_o),
    .ctx_save_o  (ctx_save_o)
);

// File: tb/iah_unit_bench.sv
module iah_unit_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       instr_end;
    logic [2:0] instr_class;
    logic       irq_pending;
    logic       irq_enable;
    logic       irq_ack_o;
    logic       ctx_save_o;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  hold_m = 1'b0;

    always #5 clk = ~clk;

    iah_unit u_iah_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_end   (instr_end),
        .instr_class (instr_class),
        .irq_pending (irq_pending),
        .irq_enable  (irq_enable),
        .irq_ack_o   (irq_ack_o),
        .ctx_save_o  (ctx_save_o)
    );

    // Hold-class codes per R5 are 1..5; 0, 6 and 7 are ordinary (R9).
    function automatic bit is_hold_code(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd5);
    endfunction

    function automatic string pick_tag(input bit r, input bit s, input logic [2:0] c,
                                       input bit e, input bit p, input bit h);
        if (r)                      return "R1";
        if (!s && is_hold_code(c))  return "R10";
        if (!s)                     return "R3";
        if (!e || !p)               return "R4";
        if (is_hold_code(c) && h)   return "R7";
        if (is_hold_code(c))        return "R5";
        if (h)                      return "R6";
        if (c >= 3'd6)              return "R9";
        return "R2";
    endfunction

    task automatic apply(input bit r, input bit s, input logic [2:0] c,
                         input bit e, input bit p);
        bit    exp_ack;
        string tag;
        @(negedge clk);
        rst         = r;
        instr_end   = s;
        instr_class = c;
        irq_enable  = e;
        irq_pending = p;
        #2;
        exp_ack = !r && s && !hold_m && !is_hold_code(c) && e && p;
        tag     = pick_tag(r, s, c, e, p, hold_m);
        n_vec++;
        if (irq_ack_o !== exp_ack) begin
            n_fail++;
            $display("FAIL %s: ack actual=%b expected=%b (cls=%0d strobe=%b en=%b pend=%b)",
                     tag, irq_ack_o, exp_ack, c, s, e, p);
        end
        n_vec++;
        if (ctx_save_o !== exp_ack) begin
            n_fail++;
            $display("FAIL R8: ctx_save actual=%b expected=%b", ctx_save_o, exp_ack);
        end
        @(posedge clk);
        if (r)      hold_m = 1'b0;
        else if (s) hold_m = is_hold_code(c);
    endtask

    initial begin
        rst = 1'b1; instr_end = 1'b0; instr_class = 3'd0;
        irq_pending = 1'b0; irq_enable = 1'b0;
        // R1: reset suppresses acknowledge even with a full request
        apply(1'b1, 1'b1, 3'd0, 1'b1, 1'b1);
        apply(1'b1, 1'b1, 3'd1, 1'b1, 1'b1);
        // R1: first qualifying boundary after release acknowledges
        apply(1'b0, 1'b1, 3'd0, 1'b1, 1'b1);
        // R7: run of hold-class boundaries, then two ordinary ones
        apply(1'b0, 1'b1, 3'd1, 1'b1, 1'b1);
        apply(1'b0, 1'b1, 3'd4, 1'b1, 1'b1);
        apply(1'b0, 1'b1, 3'd5, 1'b1, 1'b1);
        apply(1'b0, 1'b1, 3'd0, 1'b1, 1'b1);
        apply(1'b0, 1'b1, 3'd0, 1'b1, 1'b1);
        // Sweep of consecutive class pairs, request combinations and gaps
        for (int gap = 0; gap < 2; gap++) begin
            for (int a = 0; a < 8; a++) begin
                for (int pa = 0; pa < 4; pa++) begin
                    for (int b = 0; b < 8; b++) begin
                        for (int pb = 0; pb < 4; pb++) begin
                            apply(1'b0, 1'b1, 3'(a), pa[1], pa[0]);
                            if (gap == 1) apply(1'b0, 1'b0, 3'(b % 5 + 1), 1'b1, 1'b1);
                            apply(1'b0, 1'b1, 3'(b), pb[1], pb[0]);
                        end
                    end
                end
            end
        end
        // R3: idle cycles with a full request never acknowledge
        for (int i = 0; i < 8; i++) apply(1'b0, 1'b0, 3'(i), 1'b1, 1'b1);
        // R1: reset mid-deferral clears the hold flag
        apply(1'b0, 1'b1, 3'd2, 1'b1, 1'b1);
        apply(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 3'd0, 1'b1, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule